// File: doc/BRIEF.md
# Masked GPIO Bank with Event Interrupts

This block is a bank of general-purpose pins. Software reaches it through a simple word-wide register bus that completes in one cycle and has no wait states. Through that bus it sets each pin's direction, drives output levels, reads pin levels and configures event detection per pin. The block brings each pin input through a two-flop synchronizer. It drives an output level and an output enable for every pin. It detects a level or an edge condition per pin and merges the enabled events into a single interrupt line.

Every pin also has an access-mask bit. Data reads and data writes take effect only on pins whose mask bit is set. A driver that owns a few pins can therefore write the shared data word without a read-modify-write, and it cannot disturb pins it does not own. Edge events are held until software clears them by writing ones to a clear register. Level events are not held: they follow the pin for as long as the condition is true.

Top module: `gpio_bank`

## Requirements
- R1: Register word addresses are 0 data, 1 access mask, 2 direction, 3 interrupt enable, 4 sense, 5 both-edges, 6 polarity, 7 raw status (read only), 8 masked status (read only), 9 clear (write only, reads 0). After reset every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is 0.
- R2: A write to the data address changes bit i of the output latch (`pin_out`) only where access-mask bit i is 1. Bits whose mask bit is 0 keep their value.
- R3: A read of the data address returns 0 for every bit whose mask bit is 0. Where the mask bit is 1, it returns the output latch if the pin is an output and the synchronized pin input if the pin is an input.
- R4: `pin_oe` equals the direction register, where 1 makes the pin an output and 0 makes it an input.
- R5: A pin input change applied between clock edges is not visible in a data read after one rising edge. It is visible after the second rising edge.
- R6: With sense bit 1 (level), the raw status bit is 1 exactly while the synchronized pin equals the polarity bit. It is not latched, and a clear write does not remove it while the level holds.
- R7: With sense bit 0 and both-edges bit 0, polarity 1 latches the raw status on a rising transition and polarity 0 latches it on a falling transition. The other transition leaves it unchanged.
- R8: With sense bit 0 and both-edges bit 1, rising and falling transitions both latch the raw status, and the polarity bit has no effect.
- R9: A latched edge status stays 1 until a clear write has a 1 in that bit. Clear bits written as 0 leave their status unchanged.
- R10: Masked status equals raw status AND interrupt enable, and `irq` is the OR of all masked status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, valid in the same cycle |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Output latch |
| pin_oe | output | NPINS | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach is a bank in which every detection mode is active at the same time, each reacting to the same transition differently, with held edge status piling up across several steps and partial clears. The bench gives each of the eight pins a distinct combination of sense, both-edges and polarity, so the eight pins cover all eight modes. It then drives a sequence of pin words that contains rising, falling and steady bits. After each step it writes a different enable mask and a different partial clear pattern, and it checks raw status, masked status and `irq` against an arithmetic model.

// File: rtl/gpio_bank_pkg.sv
// Package: register word addresses shared by the bank's register file and its users.
// Assumes the address bus is at least 4 bits wide.
package gpio_bank_pkg;
    localparam int unsigned OFS_DATA  = 0;
    localparam int unsigned OFS_MASK  = 1;
    localparam int unsigned OFS_DIR   = 2;
    localparam int unsigned OFS_IEN   = 3;
    localparam int unsigned OFS_SENSE = 4;
    localparam int unsigned OFS_BOTH  = 5;
    localparam int unsigned OFS_POL   = 6;
    localparam int unsigned OFS_RAW   = 7;
    localparam int unsigned OFS_MIS   = 8;
    localparam int unsigned OFS_CLR   = 9;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer for the pin inputs.
// Assumes the inputs are asynchronous to clk. The output lags the inputs by two rising edges.
module gpio_in_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Capture the raw inputs and then retime them once more.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/gpio_event_unit.sv
// Module: per-pin level/edge detection with held edge status.
// Assumes synchronized inputs. Level status follows the input, and edge status is held
// until cleared. When a set and a clear meet in the same cycle, the set wins.
module gpio_event_unit #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] smp_i,
    input  logic [NPINS-1:0] sense_i,
    input  logic [NPINS-1:0] both_i,
    input  logic [NPINS-1:0] pol_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] raw_o
);
    logic [NPINS-1:0] prev_q;

    // Keep the previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= smp_i;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise, fall, edge_hit, level_hit, lat_q;

        assign rise      = smp_i[i] & ~prev_q[i];
        assign fall      = ~smp_i[i] & prev_q[i];
        assign level_hit = pol_i[i] ? smp_i[i] : ~smp_i[i];
        assign edge_hit  = ~sense_i[i] &
                           (both_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall));

        // Hold edge events until a clear bit arrives; a new event wins over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        lat_q <= 1'b0;
            else if (edge_hit) lat_q <= 1'b1;
            else if (clr_i[i]) lat_q <= 1'b0;
        end

        assign raw_o[i] = sense_i[i] ? level_hit : lat_q;

        // R9
        edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lat_q && !clr_i[i]) |=> lat_q);
        // R9
        edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !edge_hit) |=> !lat_q);
    end
endmodule

// File: rtl/gpio_regs.sv
// Module: register file and single-cycle bus decode for the pin bank.
// Assumes one access per cycle. Reads are combinational and writes take effect at the edge.
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS  = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  smp_i,
    input  logic [NPINS-1:0]  raw_i,
    input  logic [NPINS-1:0]  mis_i,
    output logic [NPINS-1:0]  out_o,
    output logic [NPINS-1:0]  dir_o,
    output logic [NPINS-1:0]  ien_o,
    output logic [NPINS-1:0]  sense_o,
    output logic [NPINS-1:0]  both_o,
    output logic [NPINS-1:0]  pol_o,
    output logic [NPINS-1:0]  clr_o
);
    logic             wr_en;
    logic [NPINS-1:0] mask_q, out_q, dir_q, ien_q, sense_q, both_q, pol_q;
    logic [NPINS-1:0] pin_view;

    assign wr_en = bus_sel & bus_wr;

    // Update the configuration registers on a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            dir_q   <= '0;
            ien_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
        end else if (wr_en) begin
            if (bus_addr == ADDR_W'(OFS_MASK))  mask_q  <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_DIR))   dir_q   <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_IEN))   ien_q   <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_SENSE)) sense_q <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_BOTH))  both_q  <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_POL))   pol_q   <= bus_wdata;
        end
    end

    // Update the output latch only on bits the access mask opens.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (wr_en && bus_addr == ADDR_W'(OFS_DATA))
            out_q <= (out_q & ~mask_q) | (bus_wdata & mask_q);
    end

    // Clear pulses last exactly one cycle, on a write to the clear address.
    assign clr_o = (wr_en && bus_addr == ADDR_W'(OFS_CLR)) ? bus_wdata : '0;

    // Outputs show the latch and inputs show the synchronized pin.
    assign pin_view = (dir_q & out_q) | (~dir_q & smp_i);

    // Select the read word for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFS_DATA):  bus_rdata = pin_view & mask_q;
                ADDR_W'(OFS_MASK):  bus_rdata = mask_q;
                ADDR_W'(OFS_DIR):   bus_rdata = dir_q;
                ADDR_W'(OFS_IEN):   bus_rdata = ien_q;
                ADDR_W'(OFS_SENSE): bus_rdata = sense_q;
                ADDR_W'(OFS_BOTH):  bus_rdata = both_q;
                ADDR_W'(OFS_POL):   bus_rdata = pol_q;
                ADDR_W'(OFS_RAW):   bus_rdata = raw_i;
                ADDR_W'(OFS_MIS):   bus_rdata = mis_i;
                default:            bus_rdata = '0;
            endcase
        end
    end

    assign out_o   = out_q;
    assign dir_o   = dir_q;
    assign ien_o   = ien_q;
    assign sense_o = sense_q;
    assign both_o  = both_q;
    assign pol_o   = pol_q;

    // R2
    masked_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_W'(OFS_DATA)) |=>
        ((out_q & ~$past(mask_q)) == ($past(out_q) & ~$past(mask_q))));
    // R2
    no_data_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bus_addr == ADDR_W'(OFS_DATA)) |=> $stable(out_q));
endmodule

// File: rtl/gpio_bank.sv
// Module: top of the masked GPIO bank, which connects the synchronizer, the event unit and the registers.
// Assumes a single clock domain for the bus. The pin inputs are asynchronous.
module gpio_bank #(
    parameter int unsigned NPINS  = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] smp, raw, mis, ien, sense, both, pol, clr, dir, outl;

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(smp)
    );

    gpio_event_unit #(.NPINS(NPINS)) u_evt (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .sense_i(sense), .both_i(both),
        .pol_i(pol), .clr_i(clr), .raw_o(raw)
    );

    gpio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .smp_i(smp), .raw_i(raw), .mis_i(mis), .out_o(outl), .dir_o(dir),
        .ien_o(ien), .sense_o(sense), .both_o(both), .pol_o(pol), .clr_o(clr)
    );

    // Gate raw events with their enables and merge them into one line.
    assign mis     = raw & ien;
    assign irq     = |mis;
    assign pin_out = outl;
    assign pin_oe  = dir;

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien != '0));
    // R10
    irq_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw != '0));
    // R4
    oe_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_oe == '0));
endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
    localparam int unsigned NPINS  = 8;
    localparam int unsigned ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [NPINS-1:0]  bus_wdata = '0;
    logic [NPINS-1:0]  bus_rdata, pin_out, pin_oe;
    logic [NPINS-1:0]  pin_in = '0;
    logic              irq;

    int errs = 0;
    int checks = 0;

    always #5 clk = ~clk;

    gpio_bank #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bwrite(input int a, input logic [NPINS-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Called away from the clock edge; the read path is combinational.
    task automatic bread(input int a, output logic [NPINS-1:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a);
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle_pins(input logic [NPINS-1:0] v);
        pin_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [NPINS-1:0] v, outm, m, d, dr, pins, prevp, lat, er, ien, c;
        logic [NPINS-1:0] sense_v, both_v, pol_v;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every register reads 0 after reset
        for (int a = 0; a < 10; a++) begin
            bread(a, v);
            chk($sformatf("R1 reg %0d", a), 32'(v), 32'h0);
        end
        chk("R1 pin_oe", 32'(pin_oe), 32'h0);
        chk("R1 pin_out", 32'(pin_out), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2: data write with all pins masked changes nothing
        @(negedge clk);
        bwrite(0, 8'hFF);
        chk("R2 fully masked write", 32'(pin_out), 32'h0);

        // R2 R3 R4: sweep masks, data words and directions
        pins = 8'hA5;
        settle_pins(pins);
        outm = '0;
        for (int k = 0; k < 16; k++) begin
            m  = NPINS'(k * 8'h3B) ^ 8'h96;
            d  = NPINS'(k * 8'h71);
            dr = NPINS'(k * 8'h1D);
            bwrite(1, m);
            bwrite(2, dr);
            bwrite(0, d);
            outm = (outm & ~m) | (d & m);
            chk($sformatf("R2 out k=%0d", k), 32'(pin_out), 32'(outm));
            chk($sformatf("R4 oe k=%0d", k), 32'(pin_oe), 32'(dr));
            bread(0, v);
            chk($sformatf("R3 read k=%0d", k), 32'(v), 32'(m & ((dr & outm) | (~dr & pins))));
        end

        // R5: input latency of two rising edges
        bwrite(2, 8'h00);
        bwrite(1, 8'hFF);
        pin_in = 8'h3C;
        @(posedge clk); @(negedge clk);
        bread(0, v);
        chk("R5 after one edge", 32'(v), 32'(pins));
        @(posedge clk); @(negedge clk);
        bread(0, v);
        chk("R5 after two edges", 32'(v), 32'h3C);
        settle_pins(8'h00);

        // R6 R7 R8 R9 R10: pin i takes mode i (sense=bit2, both=bit1, pol=bit0)
        for (int i = 0; i < NPINS; i++) begin
            sense_v[i] = i[2]; both_v[i] = i[1]; pol_v[i] = i[0];
        end
        bwrite(4, sense_v);
        bwrite(5, both_v);
        bwrite(6, pol_v);
        bwrite(9, 8'hFF);
        lat = '0;
        prevp = '0;
        for (int k = 0; k < 14; k++) begin
            v = (k[0] ? 8'hFF : 8'h00) ^ NPINS'(k * 8'h29);
            settle_pins(v);
            for (int i = 0; i < NPINS; i++) begin
                if (!sense_v[i] &&
                    ((!prevp[i] && v[i] && (both_v[i] || pol_v[i])) ||
                     (prevp[i] && !v[i] && (both_v[i] || !pol_v[i]))))
                    lat[i] = 1'b1;
                er[i] = sense_v[i] ? (v[i] == pol_v[i]) : lat[i];
            end
            prevp = v;
            ien = NPINS'(k * 8'h35) + 8'h0F;
            bwrite(3, ien);
            bread(7, c);
            chk($sformatf("R6 R7 R8 raw step %0d", k), 32'(c), 32'(er));
            bread(8, c);
            chk($sformatf("R10 masked step %0d", k), 32'(c), 32'(er & ien));
            chk($sformatf("R10 irq step %0d", k), 32'(irq), 32'(|(er & ien)));
            c = NPINS'(k * 8'h5B) ^ 8'hA5;
            bwrite(9, c);
            lat = lat & ~c;
            for (int i = 0; i < NPINS; i++)
                er[i] = sense_v[i] ? (v[i] == pol_v[i]) : lat[i];
            bread(7, c);
            chk($sformatf("R9 R6 raw after clear step %0d", k), 32'(c), 32'(er));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule